// File: doc/BRIEF.md
# PS/2 Interrupt Conditioning and Wake Detection

This block sits between an embedded keyboard controller and the host. It conditions the controller's keyboard and auxiliary (mouse) interrupt requests. Each request feeds its own latch flip-flop. That flip-flop is set by a rising edge of the raw request and cleared by a host read of the controller's data port. A per-channel mode bit picks what the host sees: either the raw request qualified by its latched copy, or the latched copy alone. The latched-only form keeps a short request pulse visible until software actually reads the data.

The block also raises a power-management wake request. The keyboard and mouse data lines are asynchronous, so each passes through a two-flop synchronizer, and a falling edge after it sets a sticky status bit for that source. Software clears a status bit by writing 1 to it. The wake output is a level. It is high while any source has both its status bit and its enable bit set, and only when the global wake enable is also set.

The raw interrupt inputs, strobes and register writes are synchronous to `clk`. The reset input is asserted asynchronously and released through a local synchronizer.

Top module: `ps2_irq_wake`

## Requirements
- R1: After reset, every software register (configuration byte, wake status, wake enables, global enable) reads 0, both latches are clear, and all three outputs are low.
- R2: A rising edge of a raw interrupt input sets that channel's latch at the next clock edge. A raw input that stays high sets nothing further after the latch is cleared.
- R3: A data-port read strobe clears both latches, so both interrupt outputs are low in the cycle after the strobe. A rising edge that coincides with the strobe leaves the latch clear.
- R4: With the channel's mode bit at 0 (keyboard: configuration bit 3, auxiliary: configuration bit 4), the interrupt output equals the raw input ANDed with the latch. It is low in the cycle of the rising edge and low again as soon as the raw input falls.
- R5: With the mode bit at 1, the interrupt output equals the latch alone. It stays high after the raw input falls, until a data-port read.
- R6: The configuration register reads back every written bit, including all bits other than 3 and 4.
- R7: A falling edge on a data line sets its status bit (bit 0 keyboard, bit 1 auxiliary) three clock edges after the line changes. A rising edge sets nothing.
- R8: Writing a status bit with 1 clears it, and writing 0 leaves it unchanged. A falling edge reaching the status logic in the same cycle as a clear leaves the bit set.
- R9: The wake output equals the global enable ANDed with the OR over both sources of status AND enable. Enable bits use the same positions as the status bits.
- R10: The enable bits and the global enable read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| kbd_irq_in | input | 1 | Raw keyboard interrupt from the controller |
| aux_irq_in | input | 1 | Raw mouse interrupt from the controller |
| data_rd | input | 1 | One-cycle strobe for a host read of the data port |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration register contents |
| kbd_dat | input | 1 | Keyboard data line, asynchronous |
| aux_dat | input | 1 | Mouse data line, asynchronous |
| stat_we | input | 1 | Wake status write strobe (write 1 to clear) |
| stat_wdata | input | 2 | Wake status clear mask |
| stat_rdata | output | 2 | Wake status bits |
| wen_we | input | 1 | Wake enable write strobe |
| wen_wdata | input | 2 | Wake enable write data |
| wen_rdata | output | 2 | Wake enable bits |
| gwake_we | input | 1 | Global wake enable write strobe |
| gwake_wdata | input | 1 | Global wake enable write data |
| gwake_rdata | output | 1 | Global wake enable |
| kbd_irq_out | output | 1 | Conditioned keyboard interrupt to the host |
| aux_irq_out | output | 1 | Conditioned mouse interrupt to the host |
| wake_out | output | 1 | Wake request level |

## Verification
The assertions check, on every cycle, the rules that relate neighbouring cycles. A data-port read leaves both outputs low. In AND mode the output never exceeds the raw input. The wake level never rises without the global enable. Status bits stay put unless a write or a detected edge acts on them, and a detected edge always sets its bit. Only the bench's scenarios can show the rest. These are the exact latency through the synchronizer, the behaviour when a clear and an edge collide, the difference between the two latch modes after the raw request falls, the full byte round trip of the configuration register, and the wake level across the combinations of status, enable and global enable.

// File: rtl/ps2iw_pkg.sv
package ps2iw_pkg;
  localparam int NUM_SRC      = 2;
  localparam int SRC_KBD      = 0;
  localparam int SRC_AUX      = 1;
  localparam int CFG_W        = 8;
  localparam int KBD_MODE_BIT = 3;
  localparam int AUX_MODE_BIT = 4;
  localparam int SYNC_STAGES  = 2;
  localparam int RST_STAGES   = 2;

  // Configuration bit that selects the latch mode of a channel
  function automatic int mode_bit(input int src);
    return (src == SRC_KBD) ? KBD_MODE_BIT : AUX_MODE_BIT;
  endfunction
endpackage

// File: rtl/ps2iw_rst_sync.sv
module ps2iw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sh_q <= '0;
    else              sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/ps2iw_irq_latch.sv
module ps2iw_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_raw,
  input  logic rd_clr,
  input  logic latch_only,
  output logic irq_out,
  output logic latched
);
  logic irq_prev_q;
  logic lat_q;
  logic lat_d;
  logic rise;

  always_comb begin
    rise = irq_raw & ~irq_prev_q;
    // clear dominates a simultaneous set
    if (rd_clr)    lat_d = 1'b0;
    else if (rise) lat_d = 1'b1;
    else           lat_d = lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_prev_q <= 1'b0;
      lat_q      <= 1'b0;
    end else begin
      irq_prev_q <= irq_raw;
      lat_q      <= lat_d;
    end
  end

  assign irq_out = latch_only ? lat_q : (irq_raw & lat_q);
  assign latched = lat_q;
endmodule

// File: rtl/ps2iw_fall_det.sv
module ps2iw_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_async,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], line_async};
  end

  // idle-high lines: reset to 1 so release of reset is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/ps2iw_wake_ctl.sv
module ps2iw_wake_ctl #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fall,
  input  logic         stat_we,
  input  logic [N-1:0] stat_wdata,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  input  logic         g_we,
  input  logic         g_wdata,
  output logic [N-1:0] stat_q,
  output logic [N-1:0] en_q,
  output logic         g_q,
  output logic         wake
);
  logic [N-1:0] stat_d;
  logic [N-1:0] en_d;
  logic         g_d;
  logic [N-1:0] clr_mask;

  always_comb begin
    clr_mask = stat_we ? stat_wdata : '0;
    // edge set applied after the clear so it wins a collision
    stat_d   = (stat_q & ~clr_mask) | fall;
    en_d     = en_we ? en_wdata : en_q;
    g_d      = g_we ? g_wdata : g_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      g_q    <= 1'b0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
      g_q    <= g_d;
    end
  end

  assign wake = g_q & |(stat_q & en_q);
endmodule

// File: rtl/ps2_irq_wake.sv
module ps2_irq_wake
  import ps2iw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kbd_irq_in,
  input  logic             aux_irq_in,
  input  logic             data_rd,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             kbd_dat,
  input  logic             aux_dat,
  input  logic             stat_we,
  input  logic [1:0]       stat_wdata,
  output logic [1:0]       stat_rdata,
  input  logic             wen_we,
  input  logic [1:0]       wen_wdata,
  output logic [1:0]       wen_rdata,
  input  logic             gwake_we,
  input  logic             gwake_wdata,
  output logic             gwake_rdata,
  output logic             kbd_irq_out,
  output logic             aux_irq_out,
  output logic             wake_out
);
  logic               rst_ns;
  logic [CFG_W-1:0]   cfg_q;
  logic [CFG_W-1:0]   cfg_d;
  logic [NUM_SRC-1:0] irq_raw;
  logic [NUM_SRC-1:0] irq_cond;
  logic [NUM_SRC-1:0] irq_latched;
  logic [NUM_SRC-1:0] dat_line;
  logic [NUM_SRC-1:0] fall_pulse;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] en_q;
  logic               gwake_q;

  ps2iw_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_ns)
  );

  always_comb begin
    cfg_d = cfg_we ? cfg_wdata : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign irq_raw[SRC_KBD]  = kbd_irq_in;
  assign irq_raw[SRC_AUX]  = aux_irq_in;
  assign dat_line[SRC_KBD] = kbd_dat;
  assign dat_line[SRC_AUX] = aux_dat;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    ps2iw_irq_latch u_lat (
      .clk       (clk),
      .rst_n     (rst_ns),
      .irq_raw   (irq_raw[i]),
      .rd_clr    (data_rd),
      .latch_only(cfg_q[mode_bit(i)]),
      .irq_out   (irq_cond[i]),
      .latched   (irq_latched[i])
    );

    ps2iw_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
      .clk       (clk),
      .rst_n     (rst_ns),
      .line_async(dat_line[i]),
      .fall      (fall_pulse[i])
    );
  end

  ps2iw_wake_ctl #(.N(NUM_SRC)) u_wake (
    .clk       (clk),
    .rst_n     (rst_ns),
    .fall      (fall_pulse),
    .stat_we   (stat_we),
    .stat_wdata(stat_wdata),
    .en_we     (wen_we),
    .en_wdata  (wen_wdata),
    .g_we      (gwake_we),
    .g_wdata   (gwake_wdata),
    .stat_q    (stat_q),
    .en_q      (en_q),
    .g_q       (gwake_q),
    .wake      (wake_out)
  );

  assign cfg_rdata   = cfg_q;
  assign stat_rdata  = stat_q;
  assign wen_rdata   = en_q;
  assign gwake_rdata = gwake_q;
  assign kbd_irq_out = irq_cond[SRC_KBD];
  assign aux_irq_out = irq_cond[SRC_AUX];
endmodule

// File: rtl/ps2iw_chk.sv
module ps2iw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       data_rd,
  input logic       kbd_irq_in,
  input logic       kbd_irq_out,
  input logic       aux_irq_out,
  input logic       kbd_mode,
  input logic       stat_we,
  input logic [1:0] stat_wdata,
  input logic [1:0] stat_q,
  input logic [1:0] fall,
  input logic       gwake,
  input logic       wake_out
);
  assert_rd_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |=> (!kbd_irq_out && !aux_irq_out));

  assert_and_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!kbd_mode && kbd_irq_out) |-> kbd_irq_in);

  assert_latch_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_mode && $rose(kbd_irq_in) && !data_rd) |=> kbd_irq_out);

  assert_edge_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fall[0] |=> stat_q[0]);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_we && fall == 2'b00) |=> (stat_q == $past(stat_q)));

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && stat_wdata[1] && !fall[1]) |=> !stat_q[1]);

  assert_gwake_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_out |-> gwake);
endmodule

bind ps2_irq_wake ps2iw_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_ns),
  .data_rd    (data_rd),
  .kbd_irq_in (kbd_irq_in),
  .kbd_irq_out(kbd_irq_out),
  .aux_irq_out(aux_irq_out),
  .kbd_mode   (cfg_rdata[3]),
  .stat_we    (stat_we),
  .stat_wdata (stat_wdata),
  .stat_q     (stat_q),
  .fall       (fall_pulse),
  .gwake      (gwake_q),
  .wake_out   (wake_out)
);

// File: tb/tb_ps2_irq_wake.sv
`timescale 1ns/1ps
module tb_ps2_irq_wake;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       kbd_irq_in, aux_irq_in, data_rd;
  logic       cfg_we;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic       kbd_dat, aux_dat;
  logic       stat_we;
  logic [1:0] stat_wdata, stat_rdata;
  logic       wen_we;
  logic [1:0] wen_wdata, wen_rdata;
  logic       gwake_we, gwake_wdata, gwake_rdata;
  logic       kbd_irq_out, aux_irq_out, wake_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ps2_irq_wake dut (.*);

  // {make_edges[1:0], enables[1:0], global, expected_wake}
  localparam logic [5:0] VEC [0:7] = '{
    6'b01_01_1_1, 6'b01_01_0_0, 6'b01_10_1_0, 6'b10_10_1_1,
    6'b11_00_1_0, 6'b11_11_1_1, 6'b00_11_1_0, 6'b10_01_1_0
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v; cyc(1); cfg_we = 1'b0;
  endtask

  task automatic clr_stat(input logic [1:0] m);
    stat_we = 1'b1; stat_wdata = m; cyc(1); stat_we = 1'b0; stat_wdata = 2'b00;
  endtask

  task automatic pulse_line(input int src);
    if (src == 0) kbd_dat = 1'b0; else aux_dat = 1'b0;
    cyc(4);
    if (src == 0) kbd_dat = 1'b1; else aux_dat = 1'b1;
    cyc(4);
  endtask

  task automatic rd_pulse();
    data_rd = 1'b1; cyc(1); data_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    kbd_irq_in = 0; aux_irq_in = 0; data_rd = 0;
    cfg_we = 0; cfg_wdata = 0; kbd_dat = 1; aux_dat = 1;
    stat_we = 0; stat_wdata = 0; wen_we = 0; wen_wdata = 0;
    gwake_we = 0; gwake_wdata = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(5);

    // R1 reset state
    chk("R1 cfg", cfg_rdata, 8'h00);
    chk("R1 stat", {6'd0, stat_rdata}, 8'h00);
    chk("R1 wen", {6'd0, wen_rdata}, 8'h00);
    chk("R1 gwake", {7'd0, gwake_rdata}, 8'h00);
    chk("R1 outs", {5'd0, kbd_irq_out, aux_irq_out, wake_out}, 8'h00);

    // R9 table walk: status/enable/global combinations
    foreach (VEC[k]) begin
      clr_stat(2'b11);
      wen_we = 1'b1; wen_wdata = VEC[k][3:2];
      gwake_we = 1'b1; gwake_wdata = VEC[k][1];
      cyc(1);
      wen_we = 1'b0; gwake_we = 1'b0;
      if (VEC[k][4]) pulse_line(0);
      if (VEC[k][5]) pulse_line(1);
      chk("R7 status from edges", {6'd0, stat_rdata}, {6'd0, VEC[k][5:4]});
      chk("R9 wake level", {7'd0, wake_out}, {7'd0, VEC[k][0]});
      chk("R10 enable readback", {5'd0, wen_rdata, gwake_rdata}, {5'd0, VEC[k][3:1]});
    end

    // R6 configuration round trip
    wr_cfg(8'hA5);
    chk("R6 cfg A5", cfg_rdata, 8'hA5);
    wr_cfg(8'h00);

    // R4 AND mode on keyboard: low in edge cycle, high after, low when raw falls
    kbd_irq_in = 1'b1; #1;
    chk("R4 edge cycle", {7'd0, kbd_irq_out}, 8'h00);
    cyc(1);
    chk("R2 latch set", {7'd0, kbd_irq_out}, 8'h01);
    kbd_irq_in = 1'b0; #1;
    chk("R4 raw low", {7'd0, kbd_irq_out}, 8'h00);
    cyc(1);
    rd_pulse();

    // R2 held level does not re-set after clear
    kbd_irq_in = 1'b1; cyc(1);
    rd_pulse(); cyc(2);
    chk("R2 held level", {7'd0, kbd_irq_out}, 8'h00);
    kbd_irq_in = 1'b0; cyc(1);

    // R5 latched-only mode on the mouse channel (cfg bit 4)
    wr_cfg(8'h10);
    aux_irq_in = 1'b1; cyc(1);
    aux_irq_in = 1'b0; cyc(2);
    chk("R5 aux holds", {7'd0, aux_irq_out}, 8'h01);
    chk("R5 kbd unaffected", {7'd0, kbd_irq_out}, 8'h00);
    rd_pulse();
    chk("R3 read clears", {7'd0, aux_irq_out}, 8'h00);

    // R5 keyboard latched-only (cfg bit 3)
    wr_cfg(8'h08);
    kbd_irq_in = 1'b1; cyc(1);
    kbd_irq_in = 1'b0; cyc(1);
    chk("R5 kbd holds", {7'd0, kbd_irq_out}, 8'h01);
    rd_pulse();
    kbd_irq_in = 1'b0; cyc(1);

    // R3 collision: rising edge with read strobe leaves latch clear
    kbd_irq_in = 1'b1; data_rd = 1'b1; cyc(1);
    data_rd = 1'b0; cyc(1);
    chk("R3 clear wins", {7'd0, kbd_irq_out}, 8'h00);
    kbd_irq_in = 1'b0; cyc(1);

    // R7 rising edge does not set; R8 write 0 no effect, write 1 clears
    clr_stat(2'b11);
    kbd_dat = 1'b0; cyc(4);
    clr_stat(2'b01);
    kbd_dat = 1'b1; cyc(4);
    chk("R7 rising no set", {6'd0, stat_rdata}, 8'h00);
    pulse_line(0);
    clr_stat(2'b00);
    chk("R8 write zero", {6'd0, stat_rdata}, 8'h01);
    clr_stat(2'b01);
    chk("R8 write one", {6'd0, stat_rdata}, 8'h00);

    // R8 collision: edge reaches status logic during a clear
    pulse_line(0);
    kbd_dat = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    stat_we = 1'b1; stat_wdata = 2'b01;
    cyc(1);
    stat_we = 1'b0; stat_wdata = 2'b00;
    chk("R8 edge wins", {6'd0, stat_rdata}, 8'h01);
    kbd_dat = 1'b1; cyc(4);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule